// File: doc/BRIEF.md
# Transmit Checksum Insertion Engine

This block sits between a transmit frame buffer and the MAC. It takes one 32-bit transmit control word per frame. If the word is owned by hardware, the block reads the frame out of a byte-addressable buffer and sends it as a byte stream. The stream marks the first byte and the last byte of the frame.

When the control word enables checksum insertion, the block makes two passes over the buffer.

- **First pass:** it sums the bytes from a per-frame start offset to the end of the frame, as a 16-bit ones-complement sum. This sum includes whatever software left in the checksum field. Software seeds that field with the folded pseudo-header sum, so one engine serves both TCP and UDP.
- **Second pass:** it streams the frame. At the stuff offset it replaces two bytes with the complemented sum.

After the last byte, the block pulses a completion strobe. With the strobe it returns the control word with the ownership bit cleared.

Top module: `tx_csum_inserter`

## Requirements
- R1: A control word is accepted only while `desc_ready` is high and `desc_valid` is high. A word with bit 31 (ownership) low is dropped: it produces no output bytes and no completion strobe.
- R2: Control word fields are as follows.
  - Bits 13:0: frame length in bytes.
  - Bits 19:14: checksum start offset in bytes.
  - Bits 27:20: checksum stuff offset in bytes.
  - Bit 28: insertion enable.
  - Bits 30 and 29: carried through unchanged.
- R3: With bit 28 low, the frame's `length` bytes appear on `out_data`, unchanged and in address order (offset 0 first), one per cycle with no gaps.
- R4: The sum covers the bytes from the start offset up to length-1. Bytes are paired from the start offset: the first byte of each pair is the high byte. A lone trailing byte is padded with a zero low byte. Carries are folded back until the sum fits in 16 bits.
- R5: With insertion active, the bytes at the stuff offset and the stuff offset plus 1 are replaced. They carry the complement of the folded sum, high byte first. All other bytes pass unchanged.
- R6: When the stuff offset is greater than length-2, insertion is skipped and the frame goes out unmodified.
- R7: `out_sop` is high only with the byte at offset 0. `out_eop` is high only with the byte at offset length-1.
- R8: Two cycles after the cycle carrying `out_eop`, `desc_done` pulses for one cycle. In that cycle `desc_wb` equals the accepted word with bit 31 cleared.
- R9: `desc_ready` is low from the cycle after acceptance until the completion strobe has ended. No byte is sent while `desc_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Control word offered |
| desc_word | input | 32 | Transmit control word |
| desc_ready | output | 1 | Engine idle, can accept a word |
| buf_addr | output | ADDR_W | Frame buffer byte address |
| buf_rdata | input | 8 | Buffer read data, one cycle after the address |
| out_valid | output | 1 | Output byte valid |
| out_sop | output | 1 | First byte of frame |
| out_eop | output | 1 | Last byte of frame |
| out_data | output | 8 | Output byte |
| desc_done | output | 1 | Frame fully sent |
| desc_wb | output | 32 | Control word with ownership cleared |

## Verification
The bench sweeps the following over a changing buffer pattern:
- frame lengths from 1 to 20 bytes;
- start offsets of both parities;
- stuff offsets at 0, at the start offset, at exactly length-2, at length-1 and far beyond the frame;
- insertion on and off.

An engine that paired bytes from address 0 instead of from the start offset would get the sum wrong for every odd start. A design that omitted the odd trailing pad or the final fold would differ on odd lengths and large sums. A design with an off-by-one in the stuff-range check would corrupt the last byte, or skip a legal insertion at length-2. Words without ownership are also offered, and the bench confirms they leave the stream silent.

// File: rtl/tx_csum_inserter.sv
module tx_csum_inserter #(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              desc_valid,
  input  logic [31:0]       desc_word,
  output logic              desc_ready,
  output logic [ADDR_W-1:0] buf_addr,
  input  logic [7:0]        buf_rdata,
  output logic              out_valid,
  output logic              out_sop,
  output logic              out_eop,
  output logic [7:0]        out_data,
  output logic              desc_done,
  output logic [31:0]       desc_wb
);
  localparam int LEN_W = 14;
  localparam int PW    = LEN_W + 1;
  localparam int ACC_W = 32;
  localparam int OWN_B = 31;
  localparam int EN_B  = 28;

  typedef enum logic [1:0] {S_IDLE, S_SUM, S_SEND, S_DONE} st_t;

  st_t             st;
  logic [30:0]     word_q;
  logic [PW-1:0]   ptr, rd_idx;
  logic            rd_v;
  logic [ACC_W-1:0] acc;

  wire [PW-1:0] len   = PW'(word_q[13:0]);
  wire [PW-1:0] start = PW'(word_q[19:14]);
  wire [PW-1:0] stuff = PW'(word_q[27:20]);
  wire          ins_ok = word_q[EN_B] && (stuff + PW'(2) <= len);
  wire          issue  = ((st == S_SUM && ins_ok) || st == S_SEND) && (ptr < len);
  wire          hi_lane = ~(rd_idx[0] ^ word_q[14]);

  wire [16:0] fold1 = {1'b0, acc[15:0]} + {1'b0, acc[31:16]};
  wire [16:0] fold2 = {1'b0, fold1[15:0]} + 17'(fold1[16]);
  wire [15:0] csum  = ~fold2[15:0];

  assign buf_addr   = ADDR_W'(ptr);
  assign desc_ready = (st == S_IDLE);
  assign desc_done  = (st == S_DONE);
  assign desc_wb    = {1'b0, word_q};
  assign out_valid  = (st == S_SEND) && rd_v;
  assign out_sop    = out_valid && (rd_idx == '0);
  assign out_eop    = out_valid && (rd_idx == len - PW'(1));
  assign out_data   = (ins_ok && rd_idx == stuff)           ? csum[15:8] :
                      (ins_ok && rd_idx == stuff + PW'(1)) ? csum[7:0]  : buf_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      word_q <= '0;
      ptr    <= '0;
      rd_idx <= '0;
      rd_v   <= 1'b0;
      acc    <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          rd_v <= 1'b0;
          if (desc_valid && desc_word[OWN_B]) begin
            word_q <= desc_word[30:0];
            ptr    <= PW'(desc_word[19:14]);
            acc    <= '0;
            st     <= S_SUM;
          end
        end
        S_SUM, S_SEND: begin
          rd_v   <= issue;
          rd_idx <= ptr;
          if (issue) ptr <= ptr + PW'(1);
          if (st == S_SUM && rd_v)
            acc <= acc + (hi_lane ? ACC_W'({buf_rdata, 8'h00}) : ACC_W'(buf_rdata));
          if (!issue && !rd_v) begin
            ptr <= '0;
            st  <= (st == S_SUM) ? S_SEND : S_DONE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_silent_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    desc_ready |-> !out_valid);
  a_r7_sop_has_byte: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop |-> out_valid);
  a_r7_eop_closes: assert property (@(posedge clk) disable iff (!rst_n)
    out_eop |=> !out_valid);
  a_r8_done_after_eop: assert property (@(posedge clk) disable iff (!rst_n)
    out_eop |-> ##2 desc_done);
  a_r9_busy_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    desc_done |-> !desc_ready);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    desc_done |=> !desc_done && desc_ready);
endmodule

// File: tb/tx_csum_inserter_tb.sv
module tx_csum_inserter_tb;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic        desc_valid = 0;
  logic [31:0] desc_word = '0;
  logic        desc_ready, out_valid, out_sop, out_eop, desc_done;
  logic [13:0] buf_addr;
  logic [7:0]  buf_rdata, out_data;
  logic [31:0] desc_wb;

  tx_csum_inserter u_dut (
    .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_word(desc_word),
    .desc_ready(desc_ready), .buf_addr(buf_addr), .buf_rdata(buf_rdata),
    .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
    .out_data(out_data), .desc_done(desc_done), .desc_wb(desc_wb));

  logic [7:0] mem [64];
  always_ff @(posedge clk) buf_rdata <= mem[buf_addr[5:0]];

  int n_chk = 0, n_bad = 0;
  bit over = 0;
  logic [7:0] cap [64];
  bit cap_sop [64], cap_eop [64];
  int cap_n = 0;
  bit done_seen = 0, gap_seen = 0, was_v = 0, ended = 0;
  logic [31:0] wb_cap;

  always @(negedge clk) begin
    if (out_valid) begin
      if (ended) gap_seen = 1;
      if (cap_n < 64) begin
        cap[cap_n] = out_data; cap_sop[cap_n] = out_sop; cap_eop[cap_n] = out_eop;
      end
      cap_n++;
    end else if (was_v) ended = 1;
    was_v = out_valid;
    if (desc_done) begin done_seen = 1; wb_cap = desc_wb; end
  end

  task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic launch(input logic [31:0] w);
    cap_n = 0; done_seen = 0; gap_seen = 0; was_v = 0; ended = 0;
    @(negedge clk);
    desc_valid = 1; desc_word = w;
    @(negedge clk);
    desc_valid = 0;
  endtask

  task automatic run_frame(input int len, input int st, input int sf, input bit en, input int seed);
    logic [31:0] w;
    logic [7:0] exp [64];
    int s, bad_i;
    bit ins;
    string tag;
    for (int i = 0; i < 64; i++) begin
      mem[i] = 8'((i * 37 + seed * 11 + 5) ^ (seed >> 2));
      exp[i] = mem[i];
    end
    w = {1'b1, 1'b1, 1'b1, en, 8'(sf), 6'(st), 14'(len)};
    ins = en && (sf + 2 <= len);
    if (ins) begin
      s = 0;
      for (int i = st; i < len; i++) s += ((i - st) % 2 == 0) ? (int'(mem[i]) << 8) : int'(mem[i]);
      while (s >> 16) s = (s & 16'hffff) + (s >> 16);
      s = ~s & 16'hffff;
      exp[sf] = 8'(s >> 8); exp[sf + 1] = 8'(s);
    end
    tag = !en ? "R3" : (ins ? "R4 R5" : "R6");
    launch(w);
    check(!desc_ready, "R9", "ready after accept", desc_ready, 0);
    for (int k = 0; k < 3000 && !done_seen; k++) @(negedge clk);
    @(negedge clk);
    check(cap_n == len && !gap_seen, "R3", "byte count", cap_n, len);
    bad_i = -1;
    for (int i = 0; i < len && i < cap_n; i++) if (cap[i] !== exp[i] && bad_i < 0) bad_i = i;
    if (bad_i >= 0) check(0, tag, $sformatf("byte %0d", bad_i), cap[bad_i], exp[bad_i]);
    else check(1, tag, "bytes", 0, 0);
    bad_i = -1;
    for (int i = 0; i < len && i < cap_n; i++)
      if (cap_sop[i] !== (i == 0) || cap_eop[i] !== (i == len - 1)) bad_i = i;
    check(bad_i < 0, "R7", "marker index", bad_i, -1);
    check(done_seen && wb_cap === (w & 32'h7fffffff), "R8", "writeback", wb_cap, w & 32'h7fffffff);
    check(desc_ready, "R9", "ready after done", desc_ready, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!over) begin
      over = 1; n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    repeat (3) @(negedge clk);
    check(desc_ready === 1 && out_valid === 0 && desc_done === 0, "R9", "reset state",
          {desc_ready, out_valid, desc_done}, 3'b100);
    rst_n = 1;
    // R1: unowned words are dropped
    launch({1'b0, 3'b111, 8'd2, 6'd0, 14'd10});
    repeat (40) @(negedge clk);
    check(cap_n == 0 && !done_seen, "R1", "unowned word output", cap_n, 0);
    check(desc_ready, "R1", "unowned word ready", desc_ready, 1);
    // R2: field sweep
    seed = 0;
    for (int len = 1; len <= 20; len++)
      for (int st = 0; st <= len; st += 3)
        for (int v = 0; v < 5; v++)
          for (int en = 0; en < 2; en++) begin
            int sf;
            case (v)
              0: sf = 0;
              1: sf = st;
              2: sf = len - 2 < 0 ? 0 : len - 2;
              3: sf = len - 1;
              default: sf = 200;
            endcase
            seed++;
            run_frame(len, st, sf, en[0], seed);
          end
    // R4 large sum forcing fold
    for (int i = 0; i < 3; i++) run_frame(20 + i, 1, 4, 1'b1, 1000 + i);
    if (!over) begin
      over = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule